// File: doc/BRIEF.md
# Character Memory Host Access Port

This block holds a 128-word by 8-bit character memory that a display engine scans and a host processor fills and verifies. The lower 64 words each stand for one on-screen character position; the upper 64 words hold cursor-segment codes. The memory address comes either from a host-owned character address register or from the engine's character counter. A hold input from the engine selects which one drives it.

The host loads the address register and writes character codes through one 8-bit data input, qualified by a host-select line. Memory readback has no parallel read bus. A host-side readout strobe clocks an 8-bit serializer. A mode input sets what each strobe does: it either captures the addressed word in parallel or shifts it out least-significant bit first. A registered serial output carries the bits, and the host polls it one bit per strobe.

Top module: `chrmem_host_port`

## Requirements
- R1: After reset the serial output `ser_out` is 0 and the host address register is 0.
- R2: A clock edge with `host_sel`=1 and `addr_ld`=1 loads `host_din[6:0]` into the host address register. `addr_ld` without `host_sel` leaves the register unchanged.
- R3: A clock edge with `host_sel`=1, `host_wr`=1 and `eng_hold`=1 writes `host_din` into the word at the host address. Every address from 0 to 127 is writable, including 63, 64 and 127.
- R4: `host_wr` has no effect on memory when `eng_hold`=0 or `host_sel`=0.
- R5: With `eng_hold`=1 the memory is addressed by the host address register. With `eng_hold`=0 it is addressed by `eng_addr`. `eng_data` shows the addressed word in the same cycle, without a clock.
- R6: A rising edge of `rd_strobe` with `mode_shift`=0 and `host_sel`=1 captures all 8 bits of the addressed word. A capture does not change `ser_out`.
- R7: A rising edge of `rd_strobe` with `mode_shift`=0 and `host_sel`=0 leaves the captured word unchanged.
- R8: Each rising edge of `rd_strobe` with `mode_shift`=1 shifts the captured word by one bit. The first shift after a capture puts bit 0 on `ser_out`, and the k-th shift puts bit k-1 there. After eight shifts, further shifts output 0.
- R9: Only a 0-to-1 transition of `rd_strobe` counts as a strobe. A strobe held high acts once. `ser_out` does not change between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 1 | Host select, qualifies address load, write and capture |
| addr_ld | input | 1 | Load the host address register from `host_din[6:0]` |
| host_wr | input | 1 | Write `host_din` into memory at the host address |
| host_din | input | 8 | Host data: address or character code |
| mode_shift | input | 1 | Readout mode: 0 = capture on strobe, 1 = shift on strobe |
| rd_strobe | input | 1 | Readout strobe, acts on its rising edge |
| ser_out | output | 1 | Registered serial readout bit |
| eng_hold | input | 1 | 1 = engine idle, host owns the memory address |
| eng_addr | input | 7 | Display engine character counter address |
| eng_data | output | 8 | Word at the selected memory address |

## Verification
Address loads, writes, captures and shifts each take effect on the clock edge that samples their inputs. Their results show on `eng_data` or `ser_out` after that one edge. `eng_data` also follows the address select within the same cycle, with no clock. The bench drives every input just after a rising edge. A scoreboard queues the expected value once the acting edge has passed, and a monitor compares it on the following falling edge. The same-cycle read path is checked after a short settle delay in a cycle that has no clock edge.

// File: rtl/chrmem_pkg.sv
package chrmem_pkg;
  localparam int unsigned CHR_DATA_W = 8;
  localparam int unsigned CHR_DEPTH  = 128;

  typedef enum logic [1:0] {
    SR_HOLD    = 2'd0,
    SR_CAPTURE = 2'd1,
    SR_SHIFT   = 2'd2
  } sr_op_e;
endpackage

// File: rtl/chrmem_addr_sel.sv
module chrmem_addr_sel #(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              eng_hold,
  input  logic [ADDR_W-1:0] eng_addr,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] mem_addr
);
  logic              addr_en;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_en = host_sel & addr_ld;
    addr_d  = addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_comb begin
    mem_addr = eng_hold ? addr_q : eng_addr;
  end
endmodule

// File: rtl/chrmem_array.sv
module chrmem_array #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 128,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata = mem[raddr];
  end
endmodule

// File: rtl/chrmem_strobe_edge.sv
module chrmem_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= strobe;
    end
  end

  always_comb begin
    rise = strobe & ~strobe_q;
  end
endmodule

// File: rtl/chrmem_serializer.sv
module chrmem_serializer
  import chrmem_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_rise,
  input  logic              mode_shift,
  input  logic              host_sel,
  input  logic [DATA_W-1:0] par_in,
  output logic              ser_out,
  output logic [DATA_W-1:0] word_q
);
  sr_op_e            op;
  logic [DATA_W-1:0] word_d;
  logic              ser_d;
  logic              word_en;

  always_comb begin
    op = SR_HOLD;
    if (strobe_rise) begin
      if (mode_shift) begin
        op = SR_SHIFT;
      end else if (host_sel) begin
        op = SR_CAPTURE;
      end
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_stage
    logic upper;
    if (i == DATA_W - 1) begin : g_top
      assign upper = 1'b0;
    end else begin : g_mid
      assign upper = word_q[i+1];
    end
    always_comb begin
      unique case (op)
        SR_CAPTURE: word_d[i] = par_in[i];
        SR_SHIFT:   word_d[i] = upper;
        default:    word_d[i] = word_q[i];
      endcase
    end
  end

  always_comb begin
    word_en = (op != SR_HOLD);
    ser_d   = (op == SR_SHIFT) ? word_q[0] : ser_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      ser_out <= 1'b0;
    end else begin
      if (word_en) begin
        word_q <= word_d;
      end
      ser_out <= ser_d;
    end
  end
endmodule

// File: rtl/chrmem_host_port.sv
module chrmem_host_port
  import chrmem_pkg::*;
#(
  parameter int unsigned DATA_W = CHR_DATA_W,
  parameter int unsigned DEPTH  = CHR_DEPTH,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              addr_ld,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_din,
  input  logic              mode_shift,
  input  logic              rd_strobe,
  output logic              ser_out,
  input  logic              eng_hold,
  input  logic [ADDR_W-1:0] eng_addr,
  output logic [DATA_W-1:0] eng_data
);
  logic [1:0]        rst_pipe;
  logic              rst_n_s;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  logic              strobe_rise;
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  always_comb begin
    rst_n_s = rst_pipe[1];
    mem_we  = host_sel & host_wr & eng_hold;
  end

  chrmem_addr_sel #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .host_sel (host_sel),
    .addr_ld  (addr_ld),
    .addr_in  (host_din[ADDR_W-1:0]),
    .eng_hold (eng_hold),
    .eng_addr (eng_addr),
    .addr_q   (addr_q),
    .mem_addr (mem_addr)
  );

  chrmem_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (addr_q),
    .wdata (host_din),
    .raddr (mem_addr),
    .rdata (eng_data)
  );

  chrmem_strobe_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .strobe (rd_strobe),
    .rise   (strobe_rise)
  );

  chrmem_serializer #(.DATA_W(DATA_W)) u_sr (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .strobe_rise (strobe_rise),
    .mode_shift  (mode_shift),
    .host_sel    (host_sel),
    .par_in      (eng_data),
    .ser_out     (ser_out),
    .word_q      (word_q)
  );
endmodule

// File: rtl/chrmem_host_port_chk.sv
module chrmem_host_port_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              host_sel,
  input logic              addr_ld,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_q,
  input logic              mode_shift,
  input logic              strobe_rise,
  input logic [DATA_W-1:0] word_q,
  input logic              ser_out
);
  a_r2_addr_load: assert property (@(posedge clk) disable iff (!rst_n_s)
    (host_sel && addr_ld) |=> (addr_q == $past(addr_in)));

  a_r2_addr_keep: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(host_sel && addr_ld) |=> $stable(addr_q));

  a_r6_capture_out_stable: assert property (@(posedge clk) disable iff (!rst_n_s)
    (strobe_rise && !mode_shift) |=> $stable(ser_out));

  a_r7_capture_ignored: assert property (@(posedge clk) disable iff (!rst_n_s)
    (strobe_rise && !mode_shift && !host_sel) |=> $stable(word_q));

  a_r8_shift_lsb: assert property (@(posedge clk) disable iff (!rst_n_s)
    (strobe_rise && mode_shift) |=> (ser_out == $past(word_q[0])));

  a_r9_out_stable: assert property (@(posedge clk) disable iff (!rst_n_s)
    !strobe_rise |=> $stable(ser_out));
endmodule

bind chrmem_host_port chrmem_host_port_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n_s     (rst_n_s),
  .host_sel    (host_sel),
  .addr_ld     (addr_ld),
  .addr_in     (host_din[ADDR_W-1:0]),
  .addr_q      (addr_q),
  .mode_shift  (mode_shift),
  .strobe_rise (strobe_rise),
  .word_q      (word_q),
  .ser_out     (ser_out)
);

// File: tb/test_chrmem_host_port.sv
`timescale 1ns/1ps
module test_chrmem_host_port;
  logic       clk;
  logic       rst_n;
  logic       host_sel, addr_ld, host_wr, mode_shift, rd_strobe, eng_hold;
  logic [7:0] host_din;
  logic [6:0] eng_addr;
  logic       ser_out;
  logic [7:0] eng_data;

  typedef struct {
    bit         on_bus;
    logic [7:0] exp;
    string      req;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  chrmem_host_port i_chrmem_host_port (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .addr_ld(addr_ld),
    .host_wr(host_wr), .host_din(host_din), .mode_shift(mode_shift),
    .rd_strobe(rd_strobe), .ser_out(ser_out), .eng_hold(eng_hold),
    .eng_addr(eng_addr), .eng_data(eng_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor: compare queued expectations on the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      sb_item_t it;
      logic [7:0] got;
      it  = sb_q.pop_front();
      got = it.on_bus ? eng_data : {7'b0, ser_out};
      n_tests++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_item(input bit on_bus, input logic [7:0] exp, input string req);
    sb_item_t it;
    it.on_bus = on_bus;
    it.exp    = exp;
    it.req    = req;
    sb_q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic set_addr(input logic [6:0] a, input logic sel);
    host_sel = sel; addr_ld = 1'b1; host_din = {1'b0, a};
    cyc();
    addr_ld = 1'b0; host_sel = 1'b0;
  endtask

  task automatic write_word(input logic [6:0] a, input logic [7:0] d);
    set_addr(a, 1'b1);
    host_sel = 1'b1; host_wr = 1'b1; host_din = d;
    cyc();
    host_wr = 1'b0; host_sel = 1'b0;
  endtask

  task automatic pulse(input logic mode, input logic sel);
    mode_shift = mode; host_sel = sel; rd_strobe = 1'b1;
    cyc();
    rd_strobe = 1'b0; host_sel = 1'b0;
    cyc();
  endtask

  task automatic shift_out(input logic [7:0] w);
    for (int k = 0; k < 8; k++) begin
      pulse(1'b1, 1'b0);
      expect_item(1'b0, {7'b0, w[k]}, "R8 shift bit");
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_sel = 0; addr_ld = 0; host_wr = 0; host_din = 0;
    mode_shift = 1'b1; rd_strobe = 0; eng_hold = 1'b1; eng_addr = 0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
    expect_item(1'b0, 8'h00, "R1 reset ser_out");

    // R1: address register is 0 after reset, so this write lands at word 0
    host_sel = 1'b1; host_wr = 1'b1; host_din = 8'h77;
    cyc();
    host_wr = 1'b0; host_sel = 1'b0;
    eng_hold = 1'b0; eng_addr = 7'd0; #1;
    expect_item(1'b1, 8'h77, "R1 reset address is 0");
    eng_hold = 1'b1;

    // R3 writes including half boundaries
    write_word(7'd5, 8'hA5);   expect_item(1'b1, 8'hA5, "R3 write 5");
    write_word(7'd63, 8'h3C);  expect_item(1'b1, 8'h3C, "R3 write 63");
    write_word(7'd64, 8'hC3);  expect_item(1'b1, 8'hC3, "R3 write 64");
    write_word(7'd127, 8'h81); expect_item(1'b1, 8'h81, "R3 write 127");
    write_word(7'd0, 8'h5A);   expect_item(1'b1, 8'h5A, "R3 write 0");

    // R2: load without host_sel is ignored
    set_addr(7'd63, 1'b0);
    expect_item(1'b1, 8'h5A, "R2 load ignored without select");
    set_addr(7'd64, 1'b1);
    expect_item(1'b1, 8'hC3, "R2 load with select");

    // R4: writes ignored while engine active or host not selected
    set_addr(7'd0, 1'b1);
    eng_hold = 1'b0; host_sel = 1'b1; host_wr = 1'b1; host_din = 8'hFF;
    cyc();
    host_wr = 1'b0; host_sel = 1'b0; eng_hold = 1'b1;
    expect_item(1'b1, 8'h5A, "R4 write ignored engine active");
    host_wr = 1'b1; host_din = 8'hEE;
    cyc();
    host_wr = 1'b0;
    expect_item(1'b1, 8'h5A, "R4 write ignored no select");

    // R5: engine address selects the word without a clock
    eng_hold = 1'b0; eng_addr = 7'd127; #1;
    expect_item(1'b1, 8'h81, "R5 engine address 127");
    eng_addr = 7'd63; #1;
    expect_item(1'b1, 8'h3C, "R5 engine address 63");
    eng_hold = 1'b1; #1;
    expect_item(1'b1, 8'h5A, "R5 host address selected");

    // R6 capture then R8 shift out LSB first
    set_addr(7'd5, 1'b1);
    pulse(1'b0, 1'b1);
    expect_item(1'b0, 8'h00, "R6 capture keeps ser_out");
    shift_out(8'hA5);
    pulse(1'b1, 1'b0);
    expect_item(1'b0, 8'h00, "R8 zero fill after eight");

    // R7: capture without select holds previous word
    set_addr(7'd63, 1'b1);
    pulse(1'b0, 1'b1);
    set_addr(7'd127, 1'b1);
    pulse(1'b0, 1'b0);
    expect_item(1'b0, 8'h00, "R7 ignored capture keeps ser_out");
    for (int k = 0; k < 8; k++) begin
      pulse(1'b1, 1'b0);
      expect_item(1'b0, {7'b0, 8'h3C >> k} & 8'h01, "R7 held word shifted");
    end

    // R9: strobe held high acts once
    pulse(1'b0, 1'b1);
    mode_shift = 1'b1; rd_strobe = 1'b1;
    repeat (3) cyc();
    expect_item(1'b0, 8'h01, "R9 held strobe one shift");
    rd_strobe = 1'b0;
    repeat (2) cyc();
    expect_item(1'b0, 8'h01, "R9 stable between strobes");
    pulse(1'b1, 1'b0);
    expect_item(1'b0, 8'h00, "R9 next strobe shifts");

    done = 1'b1;
    @(negedge clk);
    #1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule